// File: doc/BRIEF.md
# Cross-Stream Duplicate Track Cancellation and Best-Three Selector

This block receives six candidate tracks each clock. The first three come from one track-assembly stream and the last three from a second stream. A track is described by a valid bit, a quality value and a 9-bit hit word. The hit word names the segment used at each of up to four stations. Two tracks from different streams that use the same segment at some station are duplicates, and only one of them may go on to the later stages.

Nine pair units run in parallel, one for each pairing of a first-stream track with a second-stream track. Each unit compares hit words and qualities and picks the loser when the two tracks overlap. All tracks that are not cancelled are ranked by quality. The best three are written into three registered output slots. Each slot carries the source index (0..5) and the track's hit word and quality. Downstream logic reads the slots in the cycle after the inputs were applied.

Top module: `trk_dup_cancel`

## Requirements
- R1: While `rst_n` is low, every output slot shows `out_valid` = 0 on the next clock edge, whatever the inputs are.
- R2: Each input set is turned into a result that appears on the outputs exactly one clock edge later. A new input set may be applied on every cycle.
- R3: Hit word layout: bits [2:0] hold the station-1 segment, bits [4:3] station 2, bits [6:5] station 3 and bits [8:7] station 4. A field value of 0 means the station is empty. A track's length is its number of non-zero fields. Two tracks overlap when at least one station holds the same non-zero value in both; empty stations never make an overlap.
- R4: Tracks from the same stream (indices 0..2, or 3..5) are never compared. Identical tracks within one stream both survive.
- R5: When a cross-stream pair overlaps and the two lengths differ, the shorter track is cancelled, whatever the qualities are.
- R6: When an overlapping cross-stream pair has equal lengths, the track with the higher quality survives and the other is cancelled.
- R7: When an overlapping cross-stream pair has equal lengths and equal qualities, the lower-index track (the first-stream one) survives.
- R8: An input with valid = 0 never appears at the outputs and never cancels another track.
- R9: Survivors are placed in slots 0, 1 and 2 by descending quality, with ties going to the lower index first. Only the best three are output.
- R10: If fewer than three tracks survive, the unused slots are the highest-numbered ones and carry `out_valid` = 0.
- R11: All nine comparisons are decided independently. A track cancelled in one pair still cancels the tracks it beats in its other pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 6 | Valid bit per candidate; bit k is track k |
| in_hits | input | 54 | Hit words; track k at bits [9k+8:9k] |
| in_qual | input | 6*QW | Quality per candidate; track k at bits [QW*k+QW-1:QW*k] |
| out_valid | output | 3 | Slot occupied; bit s is slot s |
| out_idx | output | 9 | Source index per slot; slot s at bits [3s+2:3s] |
| out_hits | output | 27 | Hit word per slot; slot s at bits [9s+8:9s] |
| out_qual | output | 3*QW | Quality per slot; slot s at bits [QW*s+QW-1:QW*s] |

## Verification
Every result is due exactly one rising edge after its input set is applied. The bench drives inputs on the falling edge and records an expected entry with the cycle in which it is due. The monitor compares the outputs on the following falling edge, once that edge has been counted. The expected slots are computed from the requirement rules, not from the design. Vectors are applied back to back, so a result that is one cycle late or early shows up as a mismatch.

// File: rtl/trk_sel_pkg.sv
// Package: shared constants and helpers for the duplicate-track selector.
// Assumes the 9-bit hit word layout {st4[1:0], st3[1:0], st2[1:0], st1[2:0]}.
package trk_sel_pkg;
    localparam int HIT_W   = 9;
    localparam int N_STA   = 4;
    localparam int HALF    = 3;
    localparam int N_TRK   = 2 * HALF;
    localparam int IDX_W   = $clog2(N_TRK);
    localparam int LEN_W   = $clog2(N_STA + 1);

    // Extract the field of station s (0..3) as a 3-bit value.
    function automatic logic [2:0] sta_field(input logic [HIT_W-1:0] h, input int s);
        logic [2:0] f;
        case (s)
            0:       f = h[2:0];
            1:       f = {1'b0, h[4:3]};
            2:       f = {1'b0, h[6:5]};
            default: f = {1'b0, h[8:7]};
        endcase
        return f;
    endfunction

    // Number of occupied stations in a hit word.
    function automatic logic [LEN_W-1:0] seg_count(input logic [HIT_W-1:0] h);
        logic [LEN_W-1:0] n;
        n = '0;
        for (int s = 0; s < N_STA; s++)
            if (sta_field(h, s) != 3'd0) n = n + 1'b1;
        return n;
    endfunction

    // True when some occupied station holds the same segment in both words.
    function automatic logic seg_shared(input logic [HIT_W-1:0] a, input logic [HIT_W-1:0] b);
        logic r;
        r = 1'b0;
        for (int s = 0; s < N_STA; s++)
            if (sta_field(a, s) != 3'd0 && sta_field(a, s) == sta_field(b, s)) r = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/trk_pair_cmp.sv
// Pair unit: compares one first-stream track (a) against one second-stream
// track (b) and names the loser when they share a segment.
// Assumes a always has the lower input index, so a wins full ties.
module trk_pair_cmp
    import trk_sel_pkg::*;
#(
    parameter int QW = 4
) (
    input  logic             a_valid,
    input  logic [HIT_W-1:0] a_hits,
    input  logic [QW-1:0]    a_qual,
    input  logic             b_valid,
    input  logic [HIT_W-1:0] b_hits,
    input  logic [QW-1:0]    b_qual,
    output logic             kill_a,
    output logic             kill_b
);
    logic             overlap;
    logic [LEN_W-1:0] a_len;
    logic [LEN_W-1:0] b_len;

    // Hit-number bank: overlap detection and track lengths.
    always_comb begin
        overlap = a_valid && b_valid && seg_shared(a_hits, b_hits);
        a_len   = seg_count(a_hits);
        b_len   = seg_count(b_hits);
    end

    // Quality bank and decision: length first, then quality, then index.
    always_comb begin
        kill_a = 1'b0;
        kill_b = 1'b0;
        if (overlap) begin
            if (a_len > b_len)       kill_b = 1'b1;
            else if (b_len > a_len)  kill_a = 1'b1;
            else if (a_qual >= b_qual) kill_b = 1'b1;
            else                     kill_a = 1'b1;
        end
    end

    // At most one track of a pair is cancelled.
    always_comb begin
        if (!$isunknown({kill_a, kill_b}))
            assert_one_loser_R6: assert (!(kill_a && kill_b))
                else $error("pair cancelled both tracks");
    end
endmodule

// File: rtl/trk_rank.sv
// Ranker: orders surviving tracks by quality (ties to lower index) and
// routes the best NOUT into output slots. Purely combinational.
module trk_rank
    import trk_sel_pkg::*;
#(
    parameter int QW   = 4,
    parameter int NOUT = 3
) (
    input  logic [N_TRK-1:0]       keep,
    input  logic [N_TRK*HIT_W-1:0] hits,
    input  logic [N_TRK*QW-1:0]    qual,
    output logic [NOUT-1:0]        slot_valid,
    output logic [NOUT*IDX_W-1:0]  slot_idx,
    output logic [NOUT*HIT_W-1:0]  slot_hits,
    output logic [NOUT*QW-1:0]     slot_qual
);
    localparam int RANK_W = $clog2(N_TRK + 1);

    logic [N_TRK-1:0][RANK_W-1:0] rank;

    // Rank of each track = number of survivors that beat it.
    always_comb begin
        for (int k = 0; k < N_TRK; k++) begin
            rank[k] = '0;
            for (int m = 0; m < N_TRK; m++) begin
                if (m != k && keep[m] &&
                    ((qual[m*QW +: QW] > qual[k*QW +: QW]) ||
                     (qual[m*QW +: QW] == qual[k*QW +: QW] && m < k)))
                    rank[k] = rank[k] + 1'b1;
            end
        end
    end

    // Route the survivor of rank s into slot s.
    always_comb begin
        slot_valid = '0;
        slot_idx   = '0;
        slot_hits  = '0;
        slot_qual  = '0;
        for (int s = 0; s < NOUT; s++) begin
            for (int k = 0; k < N_TRK; k++) begin
                if (keep[k] && rank[k] == RANK_W'(s)) begin
                    slot_valid[s]               = 1'b1;
                    slot_idx[s*IDX_W +: IDX_W]  = IDX_W'(k);
                    slot_hits[s*HIT_W +: HIT_W] = hits[k*HIT_W +: HIT_W];
                    slot_qual[s*QW +: QW]       = qual[k*QW +: QW];
                end
            end
        end
    end
endmodule

// File: rtl/trk_dup_cancel.sv
// Top: six candidates (0..2 first stream, 3..5 second stream), nine
// cross-stream pair units, cancellation merge, ranking and output register.
// Assumes inputs are stable around the rising edge; result one clock later.
module trk_dup_cancel
    import trk_sel_pkg::*;
#(
    parameter int QW   = 4,
    parameter int NOUT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_TRK-1:0]       in_valid,
    input  logic [N_TRK*HIT_W-1:0] in_hits,
    input  logic [N_TRK*QW-1:0]    in_qual,
    output logic [NOUT-1:0]        out_valid,
    output logic [NOUT*IDX_W-1:0]  out_idx,
    output logic [NOUT*HIT_W-1:0]  out_hits,
    output logic [NOUT*QW-1:0]     out_qual
);
    logic [HALF-1:0][HALF-1:0] kill_first;
    logic [HALF-1:0][HALF-1:0] kill_second;
    logic [N_TRK-1:0]          cancelled;
    logic [N_TRK-1:0]          keep;

    logic [NOUT-1:0]           nxt_valid;
    logic [NOUT*IDX_W-1:0]     nxt_idx;
    logic [NOUT*HIT_W-1:0]     nxt_hits;
    logic [NOUT*QW-1:0]        nxt_qual;

    // Nine pair units, every first-stream track against every second-stream one.
    for (genvar gi = 0; gi < HALF; gi++) begin : g_first
        for (genvar gj = 0; gj < HALF; gj++) begin : g_second
            trk_pair_cmp #(.QW(QW)) u_pair (
                .a_valid (in_valid[gi]),
                .a_hits  (in_hits[gi*HIT_W +: HIT_W]),
                .a_qual  (in_qual[gi*QW +: QW]),
                .b_valid (in_valid[HALF+gj]),
                .b_hits  (in_hits[(HALF+gj)*HIT_W +: HIT_W]),
                .b_qual  (in_qual[(HALF+gj)*QW +: QW]),
                .kill_a  (kill_first[gi][gj]),
                .kill_b  (kill_second[gj][gi])
            );
        end
    end

    // Merge pair decisions into one cancel flag per track.
    always_comb begin
        for (int t = 0; t < HALF; t++) begin
            cancelled[t]      = |kill_first[t];
            cancelled[HALF+t] = |kill_second[t];
        end
        keep = in_valid & ~cancelled;
    end

    trk_rank #(.QW(QW), .NOUT(NOUT)) u_rank (
        .keep       (keep),
        .hits       (in_hits),
        .qual       (in_qual),
        .slot_valid (nxt_valid),
        .slot_idx   (nxt_idx),
        .slot_hits  (nxt_hits),
        .slot_qual  (nxt_qual)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_idx   <= '0;
            out_hits  <= '0;
            out_qual  <= '0;
        end else begin
            out_valid <= nxt_valid;
            out_idx   <= nxt_idx;
            out_hits  <= nxt_hits;
            out_qual  <= nxt_qual;
        end
    end

    // Output-side checks next to the register they guard.
    for (genvar gs = 0; gs < NOUT; gs++) begin : g_chk
        // A reported slot came from a track that was valid one cycle before.
        assert_src_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[gs] |-> ((($past(in_valid) >> out_idx[gs*IDX_W +: IDX_W]) & 1) == 1))
            else $error("slot %0d reports an invalid source", gs);
        if (gs > 0) begin : g_pair
            // Empty slots only at the top end.
            assert_packed_slots_R10: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[gs] |-> out_valid[gs-1])
                else $error("slot %0d filled above an empty slot", gs);
            // Quality never increases from slot to slot.
            assert_quality_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[gs] |-> out_qual[(gs-1)*QW +: QW] >= out_qual[gs*QW +: QW])
                else $error("slot %0d out of quality order", gs);
            // Two slots never name the same source.
            assert_distinct_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[gs] |-> out_idx[(gs-1)*IDX_W +: IDX_W] != out_idx[gs*IDX_W +: IDX_W])
                else $error("slot %0d repeats a source", gs);
        end
    end
endmodule

// File: tb/trk_dup_cancel_test.sv
// Scoreboard bench: driver pushes expected slots, monitor pops and compares.
module trk_dup_cancel_test;
    localparam int QW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  in_valid = '0;
    logic [53:0] in_hits = '0;
    logic [23:0] in_qual = '0;
    logic [2:0]  out_valid;
    logic [8:0]  out_idx;
    logic [26:0] out_hits;
    logic [11:0] out_qual;

    trk_dup_cancel #(.QW(QW), .NOUT(3)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hits(in_hits),
        .in_qual(in_qual), .out_valid(out_valid), .out_idx(out_idx),
        .out_hits(out_hits), .out_qual(out_qual)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        logic [2:0]  v;
        logic [8:0]  idx;
        logic [26:0] hits;
        logic [11:0] qual;
        int          due;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;
    logic        sv[6];
    logic [8:0]  sh[6];
    logic [3:0]  sq[6];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [8:0] mk(input int a, input int b, input int c, input int d);
        return {2'(d), 2'(c), 2'(b), 3'(a)};
    endfunction

    function automatic int fld(input logic [8:0] h, input int s);
        return (s == 0) ? int'(h[2:0]) : int'(h[2*s+1 +: 2]);
    endfunction

    function automatic int len(input logic [8:0] h);
        int n = 0;
        for (int s = 0; s < 4; s++) if (fld(h, s) != 0) n++;
        return n;
    endfunction

    task automatic set_trk(input int k, input logic v, input logic [8:0] h, input int q);
        sv[k] = v; sh[k] = h; sq[k] = 4'(q);
    endtask

    task automatic clear_all();
        for (int k = 0; k < 6; k++) set_trk(k, 1'b0, '0, 0);
    endtask

    // Driver: apply staged tracks, compute expected slots from the rules.
    task automatic apply(input string tag);
        exp_t e;
        logic keep[6];
        logic taken[6];
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            in_valid[k] = sv[k];
            in_hits[k*9 +: 9] = sh[k];
            in_qual[k*4 +: 4] = sq[k];
            keep[k] = sv[k];
            taken[k] = 1'b0;
        end
        for (int i = 0; i < 3; i++) begin
            for (int j = 3; j < 6; j++) begin
                logic ov = 1'b0;
                for (int s = 0; s < 4; s++)
                    if (fld(sh[i], s) != 0 && fld(sh[i], s) == fld(sh[j], s)) ov = 1'b1;
                if (sv[i] && sv[j] && ov) begin
                    if (len(sh[i]) > len(sh[j])) keep[j] = 1'b0;
                    else if (len(sh[j]) > len(sh[i])) keep[i] = 1'b0;
                    else if (sq[i] >= sq[j]) keep[j] = 1'b0;
                    else keep[i] = 1'b0;
                end
            end
        end
        e.v = '0; e.idx = '0; e.hits = '0; e.qual = '0;
        for (int s = 0; s < 3; s++) begin
            int best = -1;
            for (int k = 0; k < 6; k++)
                if (keep[k] && !taken[k] && (best < 0 || sq[k] > sq[best])) best = k;
            if (best >= 0) begin
                taken[best] = 1'b1;
                e.v[s] = 1'b1;
                e.idx[s*3 +: 3] = 3'(best);
                e.hits[s*9 +: 9] = sh[best];
                e.qual[s*4 +: 4] = sq[best];
            end
        end
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare due results on the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic ok;
            e = sb.pop_front();
            ok = (out_valid == e.v);
            for (int s = 0; s < 3; s++)
                if (e.v[s] && (out_idx[s*3 +: 3] != e.idx[s*3 +: 3] ||
                    out_hits[s*9 +: 9] != e.hits[s*9 +: 9] ||
                    out_qual[s*4 +: 4] != e.qual[s*4 +: 4])) ok = 1'b0;
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s: got v=%b idx=%h hits=%h q=%h exp v=%b idx=%h hits=%h q=%h",
                         e.tag, out_valid, out_idx, out_hits, out_qual,
                         e.v, e.idx, e.hits, e.qual);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hang exp completion");
        finish_run();
    end

    initial begin
        // R1: valid inputs during reset must not reach the outputs.
        in_valid = 6'h3f;
        in_qual = 24'h123456;
        in_hits = {6{mk(1, 1, 1, 1)}};
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (out_valid != 3'b000) begin
                errors++;
                $display("FAIL R1: got v=%b exp v=000", out_valid);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R8: nothing valid, nothing out.
        clear_all();
        set_trk(0, 1'b0, mk(1, 1, 1, 1), 9);
        apply("R8 all invalid");

        // R9: disjoint tracks with distinct qualities.
        clear_all();
        for (int k = 0; k < 6; k++) set_trk(k, 1'b1, mk(k + 1, 0, 0, 0) | 9'(0), 0);
        set_trk(0, 1'b1, mk(1, 0, 0, 0), 2);
        set_trk(1, 1'b1, mk(2, 0, 0, 0), 7);
        set_trk(2, 1'b1, mk(3, 0, 0, 0), 1);
        set_trk(3, 1'b1, mk(4, 0, 0, 0), 9);
        set_trk(4, 1'b1, mk(5, 0, 0, 0), 5);
        set_trk(5, 1'b1, mk(6, 0, 0, 0), 3);
        apply("R9 distinct qualities");

        // R9: all equal qualities, lower index first.
        for (int k = 0; k < 6; k++) sq[k] = 4'd6;
        apply("R9 quality ties");

        // R4: identical tracks inside the first stream both survive.
        clear_all();
        set_trk(0, 1'b1, mk(2, 1, 1, 0), 8);
        set_trk(1, 1'b1, mk(2, 1, 1, 0), 7);
        apply("R4 same stream duplicates");

        // R5: longer track 0 cancels shorter, better-quality track 3.
        clear_all();
        set_trk(0, 1'b1, mk(1, 2, 3, 1), 2);
        set_trk(3, 1'b1, mk(0, 2, 0, 2), 15);
        apply("R5 longer wins");

        // R6: equal length, track 4 has higher quality and cancels track 1.
        clear_all();
        set_trk(1, 1'b1, mk(3, 1, 0, 0), 4);
        set_trk(4, 1'b1, mk(3, 2, 0, 0), 10);
        apply("R6 higher quality wins");

        // R7: equal length, equal quality, track 2 kept over track 5.
        clear_all();
        set_trk(2, 1'b1, mk(0, 3, 2, 0), 5);
        set_trk(5, 1'b1, mk(0, 3, 1, 0), 5);
        apply("R7 index tie break");

        // R3: empty stations match but never count as shared.
        clear_all();
        set_trk(0, 1'b1, mk(0, 1, 0, 2), 3);
        set_trk(3, 1'b1, mk(0, 2, 0, 1), 6);
        apply("R3 empty stations");

        // R3: station-1 field uses all three bits.
        clear_all();
        set_trk(1, 1'b1, mk(5, 0, 0, 0), 3);
        set_trk(5, 1'b1, mk(1, 1, 0, 0), 6);
        apply("R3 station 1 field width");

        // R8: an invalid longer track does not cancel.
        clear_all();
        set_trk(0, 1'b1, mk(1, 1, 0, 0), 4);
        set_trk(3, 1'b0, mk(1, 1, 1, 1), 9);
        apply("R8 invalid does not cancel");

        // R10: two survivors leave slot 2 empty.
        clear_all();
        set_trk(2, 1'b1, mk(1, 0, 0, 0), 1);
        set_trk(4, 1'b1, mk(2, 0, 0, 0), 12);
        apply("R10 unfilled slot");

        // R11: track 3 is cancelled by track 0 but still cancels track 1.
        clear_all();
        set_trk(0, 1'b1, mk(1, 1, 1, 1), 1);
        set_trk(3, 1'b1, mk(1, 2, 2, 0), 14);
        set_trk(1, 1'b1, mk(4, 2, 0, 0), 15);
        apply("R11 independent decisions");

        // R2: back-to-back random vectors with frequent overlaps.
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < 6; k++)
                set_trk(k, 1'($urandom_range(0, 3) != 0),
                        mk($urandom_range(0, 2), $urandom_range(0, 2),
                           $urandom_range(0, 2), $urandom_range(0, 2)),
                        $urandom_range(0, 3));
            apply("R2 back to back");
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule